// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

The block is a 16-bit up-counter that advances on a tick derived from the bus clock by a selectable power-of-two divider. It counts up to a programmed modulo value. On the tick where it equals that value, it returns to zero and raises an overflow flag. With the enable set, the flag drives the interrupt output.

Software reaches the block through a byte-wide register bus with an address, a one-cycle read strobe, a one-cycle write strobe, write data and combinational read data. One control byte holds the following fields:

- the overflow flag
- the interrupt enable
- a stop bit
- a self-clearing counter reset
- the divider select

The counter and the modulo value are each reachable as high and low bytes. Reading the high byte of the counter freezes a copy of the low byte, so that a 16-bit value read as two bytes is consistent. The overflow flag clears only through a read-then-write-0 handshake. That handshake is abandoned if a new overflow arrives in between, so an overflow event is never lost.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control byte reads 0x20 (stopped), the counter reads 0x0000, the modulo value reads 0xFFFF, irq_o is low, and the counter does not advance while stopped.
- R2: The control byte sits at address 0. Its bits are: 7 overflow flag, 6 interrupt enable, 5 stop, 4 counter reset (write-only), 3 unused, 2..0 divider select. Bits 4 and 3 always read 0.
- R3: With divider select n, where n is 0 to 6, the counter advances once every 2^n clock cycles. Select value 7 divides by 64.
- R4: On a tick where the counter equals the modulo value, the counter becomes 0x0000 and the overflow flag sets.
- R5: Software clears the flag by reading the control byte while the flag is set and then writing the control byte with bit 7 at 0.
- R6: A write of 0 to bit 7 that has no flag-set read before it, since the last control write, leaves the flag set.
- R7: If an overflow occurs between the arming read and the write of 0, the write leaves the flag set.
- R8: Writing 1 to bit 7 never sets the flag.
- R9: irq_o is high exactly while the flag and the interrupt enable are both set.
- R10: Writing 1 to bit 4 clears the counter and the divider together. The next tick then comes a full 2^n cycles later.
- R11: While the stop bit is set, the counter and the divider hold their values.
- R12: Reading the counter high byte captures the low byte. The next low-byte read returns that capture and releases it; later low-byte reads return the live value.
- R13: Addresses 1 and 2 hold the counter high and low bytes, and addresses 3 and 4 hold the modulo high and low bytes. Each byte can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions assume the following about the bus inputs:

- a read or write strobe lasts one cycle per access;
- rd_i and wr_i are never high in the same cycle;
- the address and write data are stable for the whole strobe cycle.

The arm-and-clear checks, the latch checks and the counter-hold checks depend on those assumptions. The bench drives each access from a task at the falling clock edge, raising exactly one strobe for exactly one cycle. Before it attempts a flag clear, it stops the counter, except in the deliberate overflow-race case.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_MOD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_MOD_LO = 3'd4;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int STOP_BIT = 5;
  localparam int CRST_BIT = 4;
  localparam int PS_LSB   = 0;
  localparam int PS_W     = 3;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rd;
    logic cnt_hi_wr;
    logic cnt_lo_wr;
    logic cnt_hi_rd;
    logic cnt_lo_rd;
    logic mod_hi_wr;
    logic mod_lo_wr;
  } strb_t;
endpackage

// File: rtl/modtmr_prescale.sv
module modtmr_prescale #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [SEL_W-1:0] SHIFT_CAP = SEL_W'(MAX_SHIFT);

  logic [MAX_SHIFT-1:0] pre_q;
  logic [MAX_SHIFT-1:0] mask;
  logic [SEL_W-1:0]     shift;

  assign shift = (sel_i > SHIFT_CAP) ? SHIFT_CAP : sel_i;

  for (genvar i = 0; i < MAX_SHIFT; i++) begin : g_mask
    assign mask[i] = (shift > SEL_W'(i));
  end

  // tick on the last state of each 2^shift window
  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
  end

  AST_PRE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clr_i |=> $stable(pre_q)); // R11
  AST_PRE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0); // R10
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             cnt_hi_wr_i,
  input  logic             cnt_lo_wr_i,
  input  logic             mod_hi_wr_i,
  input  logic             mod_lo_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_o,
  output logic             wrap_o
);
  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cnt_q, mod_q;
  logic             cpu_wr;

  assign cpu_wr = cnt_hi_wr_i || cnt_lo_wr_i;
  assign wrap_o = tick_i && !clr_i && !cpu_wr && (cnt_q == mod_q);
  assign cnt_o  = cnt_q;
  assign mod_o  = mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (cnt_hi_wr_i) cnt_q <= {wdata_i[HI_W-1:0], cnt_q[7:0]};
    else if (cnt_lo_wr_i) cnt_q <= {cnt_q[CNT_W-1:8], wdata_i};
    else if (tick_i)      cnt_q <= (cnt_q == mod_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mod_q <= '1;
    else if (mod_hi_wr_i) mod_q <= {wdata_i[HI_W-1:0], mod_q[7:0]};
    else if (mod_lo_wr_i) mod_q <= {mod_q[CNT_W-1:8], wdata_i};
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0); // R4
  AST_CRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i && !cpu_wr |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/modtmr_ctrl.sv
module modtmr_ctrl
  import modtmr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_wr_i,
  input  logic            ctrl_rd_i,
  input  logic [7:0]      wdata_i,
  input  logic            wrap_i,
  output logic            stop_o,
  output logic [PS_W-1:0] ps_o,
  output logic            crst_o,
  output logic [7:0]      rdata_o,
  output logic            irq_o
);
  logic            flag_q, ie_q, stop_q, armed_q;
  logic [PS_W-1:0] ps_q;
  logic            clr_req;

  assign clr_req = ctrl_wr_i && !wdata_i[FLAG_BIT] && armed_q;
  assign crst_o  = ctrl_wr_i && wdata_i[CRST_BIT];
  assign stop_o  = stop_q;
  assign ps_o    = ps_q;
  assign irq_o   = flag_q && ie_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[FLAG_BIT] = flag_q;
    rdata_o[IE_BIT]   = ie_q;
    rdata_o[STOP_BIT] = stop_q;
    rdata_o[PS_LSB +: PS_W] = ps_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= CTRL_RESET[IE_BIT];
      stop_q <= CTRL_RESET[STOP_BIT];
      ps_q   <= CTRL_RESET[PS_LSB +: PS_W];
    end else if (ctrl_wr_i) begin
      ie_q   <= wdata_i[IE_BIT];
      stop_q <= wdata_i[STOP_BIT];
      ps_q   <= wdata_i[PS_LSB +: PS_W];
    end
  end

  // a new overflow wins over a pending clear and disarms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap_i)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wrap_i || ctrl_wr_i)       armed_q <= 1'b0;
      else if (ctrl_rd_i && flag_q)  armed_q <= 1'b1;
    end
  end

  AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q); // R7
  AST_FLAG_FALL_NEEDS_WR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(ctrl_wr_i) && !$past(wdata_i[FLAG_BIT])); // R5
  AST_ONE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && wdata_i[FLAG_BIT] && !flag_q && !wrap_i |=> !flag_q); // R8
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SHIFT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  strb_t            strb;
  logic [CNT_W-1:0] cnt, modv;
  logic [PS_W-1:0]  ps;
  logic [7:0]       ctrl_rdata;
  logic [7:0]       lat_q;
  logic             lat_vld_q;
  logic             stop, crst, tick, wrap;

  always_comb begin
    strb = '0;
    strb.ctrl_wr   = wr_i && (addr_i == A_CTRL);
    strb.ctrl_rd   = rd_i && (addr_i == A_CTRL);
    strb.cnt_hi_wr = wr_i && (addr_i == A_CNT_HI);
    strb.cnt_lo_wr = wr_i && (addr_i == A_CNT_LO);
    strb.cnt_hi_rd = rd_i && (addr_i == A_CNT_HI);
    strb.cnt_lo_rd = rd_i && (addr_i == A_CNT_LO);
    strb.mod_hi_wr = wr_i && (addr_i == A_MOD_HI);
    strb.mod_lo_wr = wr_i && (addr_i == A_MOD_LO);
  end

  modtmr_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (strb.ctrl_wr),
    .ctrl_rd_i (strb.ctrl_rd),
    .wdata_i   (wdata_i),
    .wrap_i    (wrap),
    .stop_o    (stop),
    .ps_o      (ps),
    .crst_o    (crst),
    .rdata_o   (ctrl_rdata),
    .irq_o     (irq_o)
  );

  modtmr_prescale #(.SEL_W(PS_W), .MAX_SHIFT(MAX_SHIFT)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!stop),
    .clr_i  (crst),
    .sel_i  (ps),
    .tick_o (tick)
  );

  modtmr_count #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (crst),
    .tick_i      (tick),
    .cnt_hi_wr_i (strb.cnt_hi_wr),
    .cnt_lo_wr_i (strb.cnt_lo_wr),
    .mod_hi_wr_i (strb.mod_hi_wr),
    .mod_lo_wr_i (strb.mod_lo_wr),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt),
    .mod_o       (modv),
    .wrap_o      (wrap)
  );

  // low-byte capture for coherent two-byte counter reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q     <= '0;
      lat_vld_q <= 1'b0;
    end else if (strb.cnt_hi_rd) begin
      lat_q     <= cnt[7:0];
      lat_vld_q <= 1'b1;
    end else if (strb.cnt_lo_rd) begin
      lat_vld_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:   rdata_o = ctrl_rdata;
      A_CNT_HI: rdata_o = cnt[CNT_W-1 -: 8];
      A_CNT_LO: rdata_o = lat_vld_q ? lat_q : cnt[7:0];
      A_MOD_HI: rdata_o = modv[CNT_W-1 -: 8];
      A_MOD_LO: rdata_o = modv[7:0];
      default:  rdata_o = '0;
    endcase
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.cnt_hi_rd |=> lat_vld_q && (lat_q == $past(cnt[7:0]))); // R12
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_vld_q && !strb.cnt_lo_rd && !strb.cnt_hi_rd |=> lat_vld_q && $stable(lat_q)); // R12
endmodule

// File: tb/test_modtmr_top.sv
`timescale 1ns/1ps
module test_modtmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  localparam logic [2:0] CTRL = 3'd0, CHI = 3'd1, CLO = 3'd2, MHI = 3'd3, MLO = 3'd4;

  always #10 clk = ~clk;

  modtmr_top i_modtmr_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at one
  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] hi_a, output logic [15:0] v);
    logic [7:0] h, l;
    do_rd(hi_a, h); do_rd(hi_a + 3'd1, l);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] c; logic [15:0] v;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    do_rd(CTRL, c);  chk("R1 ctrl", {8'd0, c}, 16'h0020);
    rd16(CHI, v);    chk("R1 cnt", v, 16'h0000);
    rd16(MHI, v);    chk("R1 mod", v, 16'hFFFF);
    repeat (10) @(negedge clk);
    rd16(CHI, v);    chk("R1 stopped", v, 16'h0000);
  endtask

  task automatic t_layout();
    logic [7:0] c;
    do_wr(CTRL, 8'hFF); do_rd(CTRL, c);
    chk("R2 layout", {8'd0, c}, 16'h0067);
    do_wr(CTRL, 8'hA0); do_rd(CTRL, c);
    chk("R8 write one", {8'd0, c}, 16'h0020);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    do_wr(MHI, 8'hAB); do_wr(MLO, 8'hCD); rd16(MHI, v);
    chk("R13 mod", v, 16'hABCD);
    do_wr(CHI, 8'h12); do_wr(CLO, 8'h34); rd16(CHI, v);
    chk("R13 cnt", v, 16'h1234);
    do_wr(MHI, 8'hFF); do_wr(MLO, 8'hFF);
  endtask

  task automatic t_prescale(input logic [2:0] n, input int m, input logic [15:0] exp);
    logic [15:0] v;
    do_wr(CTRL, 8'h90 | {5'd0, n});
    repeat (m) @(negedge clk);
    rd16(CHI, v);
    chk($sformatf("R3 div sel %0d", n), v, exp);
    do_wr(CTRL, 8'hA0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_wr(MHI, 8'h00); do_wr(MLO, 8'h05);
    do_wr(CTRL, 8'hD0);
    repeat (5) @(negedge clk);
    chk("R4 before wrap", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R4 flag on wrap", {15'd0, irq}, 16'd1);
    rd16(CHI, v);
    chk("R4 cnt zero", v, 16'h0000);
    do_wr(CTRL, 8'hE0);
  endtask

  task automatic t_irq();
    logic [7:0] c;
    chk("R9 irq on", {15'd0, irq}, 16'd1);
    do_wr(CTRL, 8'hA0);
    chk("R9 irq masked", {15'd0, irq}, 16'd0);
    do_rd(CTRL, c);
    chk("R9 flag kept", {8'd0, c}, 16'h00A0);
  endtask

  task automatic t_noarm();
    logic [7:0] c;
    do_wr(CTRL, 8'hA0);
    do_wr(CTRL, 8'h20);
    do_rd(CTRL, c);
    chk("R6 unarmed clear", {8'd0, c}, 16'h00A0);
  endtask

  task automatic t_clear();
    logic [7:0] c;
    do_wr(CTRL, 8'h20);
    do_rd(CTRL, c);
    chk("R5 cleared", {8'd0, c}, 16'h0020);
  endtask

  task automatic t_race();
    logic [7:0] c;
    do_wr(MHI, 8'h00); do_wr(MLO, 8'h03);
    do_wr(CTRL, 8'h90);
    repeat (4) @(negedge clk);
    do_rd(CTRL, c);
    chk("R7 first overflow", {8'd0, c}, 16'h0080);
    repeat (4) @(negedge clk);
    do_wr(CTRL, 8'h20);
    do_rd(CTRL, c);
    chk("R7 clear lost to overflow", {8'd0, c}, 16'h00A0);
    do_wr(CTRL, 8'h20);
    do_rd(CTRL, c);
    chk("R5 clear after rearm", {8'd0, c}, 16'h0020);
    do_wr(MHI, 8'hFF); do_wr(MLO, 8'hFF);
  endtask

  task automatic t_crst();
    logic [15:0] v;
    do_wr(CTRL, 8'h93);
    repeat (30) @(negedge clk);
    do_wr(CTRL, 8'h93);
    repeat (7) @(negedge clk);
    rd16(CHI, v); chk("R10 no tick yet", v, 16'h0000);
    do_wr(CTRL, 8'h93);
    repeat (8) @(negedge clk);
    rd16(CHI, v); chk("R10 first tick", v, 16'h0001);
  endtask

  task automatic t_stop();
    logic [15:0] v1, v2;
    do_wr(CTRL, 8'hA3);
    rd16(CHI, v1);
    repeat (20) @(negedge clk);
    rd16(CHI, v2);
    chk("R11 held", v2, v1);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    do_wr(CHI, 8'h12); do_wr(CLO, 8'hFE);
    do_wr(CTRL, 8'h80);
    @(negedge clk);
    do_rd(CHI, d); chk("R12 high", {8'd0, d}, 16'h0012);
    repeat (3) @(negedge clk);
    do_rd(CLO, d); chk("R12 latched low", {8'd0, d}, 16'h00FF);
    do_rd(CLO, d); chk("R12 live low", {8'd0, d}, 16'h0004);
    do_wr(CTRL, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_bytes();
    t_prescale(3'd0, 10, 16'd10);
    t_prescale(3'd2, 21, 16'd5);
    t_prescale(3'd7, 200, 16'd3);
    t_wrap();
    t_irq();
    t_noarm();
    t_clear();
    t_race();
    t_crst();
    t_stop();
    t_latch();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule